// File: doc/BRIEF.md
# Speaker enable and timer gate status port

This block is a one-byte register port on a byte-wide I/O bus. It holds two control bits. One drives the gate input of an external interval-timer channel. The other is a stored enable that passes on to the speaker tone path. The interval timer is outside the block: its gate comes from this port, and its output level returns through an input pin.

A read of the port returns one status byte. That byte holds the two control bits, the timer output level and a refresh indicator. Software polls the refresh indicator for pacing. The indicator flips on every qualified read, so reading the port has a side effect. Writes never touch the indicator.

The port sits at one byte address, set by a parameter that defaults to 0x61. All outputs are registered. Read data appears one clock after the read strobe, together with a one-cycle acknowledge, and is held until the next qualified read.

Top module: `spk_port_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, the timer gate, the speaker enable, the refresh indicator state, the read data and the read acknowledge are all 0.
- R2: A write strobe with the port address loads write-data bit 0 into the timer gate output. The new level is visible on the cycle after the strobe edge.
- R3: The same write loads write-data bit 1 into the speaker enable output, visible on the cycle after the strobe edge. Write-data bits 7..2 have no effect.
- R4: Read data bit 0 is the gate level and bit 1 is the speaker enable, as held just before the read edge.
- R5: Read data bit 5 is the level of the timer output input, sampled at the read edge.
- R6: Read data bit 4 is the refresh indicator. The indicator inverts once on each qualified read, and the value returned is the inverted one, so the first read after reset returns 1.
- R7: Read data bits 2, 3, 6 and 7 are always 0.
- R8: A write does not change the refresh indicator. Strobes with any other address change no state and no output.
- R9: The read acknowledge is high for exactly the cycle after each qualified read. The read data holds its value until the next qualified read.
- R10: When a read and a write hit the port in the same cycle, the read returns the state from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered status byte |
| bus_rack | output | 1 | Pulses on the cycle read data is updated |
| tmr_gate | output | 1 | Gate level for the external timer channel |
| spk_data_en | output | 1 | Stored speaker data enable |
| tmr_out | input | 1 | Output level of the external timer channel |

## Verification
The assertions check several properties on every cycle. Each port write must reach the gate and the enable. Each qualified read must flip the refresh state exactly once, and nothing else may move it. The unused read bits must stay at zero, and the read data must hold between reads. Some behaviours only the bench scenarios show: the exact sequence of refresh values across reads separated by writes, the first-read value after reset, the ordering when a read and a write collide, and the fact that strobes to other addresses leave every output untouched. The bench also compares a behavioural model against all outputs on every clock.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int DATA_W      = 8;
  localparam int GATE_POS    = 0;
  localparam int EN_POS      = 1;
  localparam int REFRESH_POS = 4;
  localparam int TOUT_POS    = 5;

  // Assemble the status byte; unlisted positions stay zero.
  function automatic logic [DATA_W-1:0] pack_status(input logic gate,
                                                    input logic en,
                                                    input logic refresh,
                                                    input logic tout);
    logic [DATA_W-1:0] v;
    v = '0;
    v[GATE_POS]    = gate;
    v[EN_POS]      = en;
    v[REFRESH_POS] = refresh;
    v[TOUT_POS]    = tout;
    return v;
  endfunction
endpackage

// File: rtl/spk_addr_dec.sv
module spk_addr_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h61
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit
);
  logic match;
  assign match  = (addr == PORT_ADDR);
  assign rd_hit = rd & match;
  assign wr_hit = wr & match;
endmodule

// File: rtl/spk_ctrl_reg.sv
module spk_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic gate_in,
  input  logic en_in,
  output logic gate_q,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_hit) begin
      gate_q <= gate_in;
      en_q   <= en_in;
    end
  end

  a_r2_gate_loaded: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> gate_q == $past(gate_in));
  a_r3_enable_loaded: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> en_q == $past(en_in));
  a_r8_ctrl_held: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(gate_q) && $stable(en_q));
endmodule

// File: rtl/spk_refresh.sv
module spk_refresh (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  output logic tgl_q
);
  always_ff @(posedge clk) begin
    if (rst)         tgl_q <= 1'b0;
    else if (rd_hit) tgl_q <= ~tgl_q;
  end

  a_r6_flip_per_read: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> tgl_q != $past(tgl_q));
  a_r8_no_flip_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(tgl_q));
endmodule

// File: rtl/spk_port_top.sv
module spk_port_top #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h61
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [spk_pkg::DATA_W-1:0] bus_wdata,
  output logic [spk_pkg::DATA_W-1:0] bus_rdata,
  output logic                       bus_rack,
  output logic                       tmr_gate,
  output logic                       spk_data_en,
  input  logic                       tmr_out
);
  import spk_pkg::*;

  logic rd_hit, wr_hit, tgl_q;

  spk_addr_dec #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  spk_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit),
    .gate_in(bus_wdata[GATE_POS]), .en_in(bus_wdata[EN_POS]),
    .gate_q(tmr_gate), .en_q(spk_data_en)
  );

  spk_refresh u_ref (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .tgl_q(tgl_q)
  );

  // Read data uses the pre-access state; refresh returns its flipped value.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_rack  <= 1'b0;
    end else begin
      bus_rack <= rd_hit;
      if (rd_hit)
        bus_rdata <= pack_status(tmr_gate, spk_data_en, ~tgl_q, tmr_out);
    end
  end

  a_r4_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> bus_rdata[GATE_POS] == $past(tmr_gate) &&
               bus_rdata[EN_POS] == $past(spk_data_en));
  a_r5_timer_sampled: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> bus_rdata[TOUT_POS] == $past(tmr_out));
  a_r7_spare_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[3:2] == 2'b00 && bus_rdata[7:6] == 2'b00);
  a_r9_data_held: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(bus_rdata) && !bus_rack);
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> bus_rack);
endmodule

// File: tb/sim_spk_port_top.sv
`timescale 1ns/1ps
module sim_spk_port_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rack, tmr_gate, spk_data_en;
  logic        tmr_out = 0;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spk_port_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rack(bus_rack),
    .tmr_gate(tmr_gate), .spk_data_en(spk_data_en), .tmr_out(tmr_out)
  );

  // Behavioural reference model
  bit m_gate, m_en, m_tgl, m_ack;
  bit [7:0] m_rdata;
  always @(posedge clk) begin
    bit rh, wh;
    rh = bus_rd && bus_addr == 16'h61;
    wh = bus_wr && bus_addr == 16'h61;
    if (rst) begin
      m_gate = 0; m_en = 0; m_tgl = 0; m_rdata = 0; m_ack = 0;
    end else begin
      m_ack = rh;
      if (rh) begin
        m_tgl = !m_tgl;
        m_rdata = 8'h00;
        m_rdata[0] = m_gate; m_rdata[1] = m_en;
        m_rdata[4] = m_tgl;  m_rdata[5] = tmr_out;
      end
      if (wh) begin
        m_gate = bus_wdata[0]; m_en = bus_wdata[1];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) if (!done) begin
    chk("R2 gate", tmr_gate, m_gate);
    chk("R3 enable", spk_data_en, m_en);
    chk("R4 R5 R6 R7 rdata", bus_rdata, m_rdata);
    chk("R9 ack", bus_rack, m_ack);
  end

  task automatic acc(bit rd, bit wr, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  initial begin : watchdog
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 gate", tmr_gate, 0);
    chk("R1 enable", spk_data_en, 0);
    chk("R1 ack", bus_rack, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after release", {tmr_gate, spk_data_en, bus_rack}, 0);
    // R6: first read after reset returns refresh=1
    acc(1, 0, 16'h61, 0);
    chk("R6 first read", bus_rdata[4], 1);
    chk("R7 spare zero", bus_rdata & 8'hCC, 0);
    // R2/R3: write both bits, R3 high bits ignored
    acc(0, 1, 16'h61, 8'hFF);
    chk("R2 gate set", tmr_gate, 1);
    chk("R3 en set", spk_data_en, 1);
    acc(0, 1, 16'h61, 8'hFC);
    chk("R3 high bits ignored", {spk_data_en, tmr_gate}, 0);
    acc(0, 1, 16'h61, 8'h02);
    // R5 with timer high; R4 readback
    tmr_out = 1;
    acc(1, 0, 16'h61, 0);
    chk("R4 readback", bus_rdata[1:0], 2'b10);
    chk("R5 timer bit", bus_rdata[5], 1);
    chk("R6 second read", bus_rdata[4], 0);
    // R8: writes between reads do not move refresh
    prev = bus_rdata[4];
    acc(0, 1, 16'h61, 8'h01);
    acc(0, 1, 16'h61, 8'h00);
    acc(1, 0, 16'h61, 0);
    chk("R8 write keeps refresh", bus_rdata[4], !prev);
    // R8: other address changes nothing
    prev = bus_rdata[4];
    acc(1, 1, 16'h60, 8'h03);
    chk("R8 foreign addr gate/en", {spk_data_en, tmr_gate}, 0);
    chk("R8 foreign addr ack", bus_rack, 0);
    acc(1, 0, 16'h61, 0);
    chk("R8 foreign read no flip", bus_rdata[4], !prev);
    // R10: simultaneous read and write
    acc(1, 1, 16'h61, 8'h03);
    chk("R10 read old state", bus_rdata[1:0], 2'b00);
    chk("R10 write applied", {spk_data_en, tmr_gate}, 2'b11);
    // R9: data held while idle
    prev = bus_rdata[4];
    tmr_out = 0;
    repeat (4) @(negedge clk);
    chk("R9 held", bus_rdata[4], prev);
    chk("R9 ack low", bus_rack, 0);
    // back-to-back reads (R6)
    @(negedge clk); bus_rd = 1; bus_addr = 16'h61;
    @(negedge clk); prev = bus_rdata[4];
    @(negedge clk); bus_rd = 0;
    chk("R6 back-to-back", bus_rdata[4], !prev);
    // mixed random traffic checked by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_rd = $urandom_range(0, 1);
      bus_wr = $urandom_range(0, 1);
      bus_addr = ($urandom_range(0, 3) == 0) ? 16'h0060 + 16'($urandom_range(0, 3)) : 16'h61;
      bus_wdata = 8'($urandom);
      tmr_out = $urandom_range(0, 1);
    end
    @(negedge clk); bus_rd = 0; bus_wr = 0;
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule